// File: doc/BRIEF.md
# System Clock Mode Controller

This block decides whether a small microcontroller runs from its slow subclock or its fast main clock. Software sets the mode through one 8-bit control/status register. The block never switches to the main clock at once. First it counts down an oscillation stabilization wait, and a two-bit field in the register sets the length of that wait. The same wait is used when a wakeup event brings the device out of main-stop mode, and also at reset. A read-only monitor bit tells software whether main clock mode is fully active.

The register also holds a two-bit speed select, which goes out to the divider for the CPU and peripheral clock. That select has no path to the timebase or watch clocks. Two options come from pins:

- a reset-time value for the wait-select field;
- a single-clock option, which holds the block in main clock mode.

A write that tries to change the wait length during a wait is refused and flagged. The oscillators, the clock multiplexer and the divider lie outside this block.

Top module: `clkmode_ctrl`

## Requirements
- R1: In reset the register reads with bit 7 = 0, bits 6:5 = 0, bits 4:3 = the option value, bit 2 = 1 and bits 1:0 = 0. The block is in a stabilization wait, and bit 7 (monitor) goes to 1 exactly 2^E clock edges after reset is released. E is 2, 12, 14 or 16 for option values 0, 1, 2 or 3.
- R2: A write with bit 2 = 0 puts the block in subclock mode on the next edge: monitor = 0, main_sel = 0.
- R3: In subclock mode, a write with bit 2 = 1 starts a wait whose length comes from the bits 4:3 being written (0→4, 1→4096, 2→16384, 3→65536 edges). The monitor reads 0 for the whole wait and turns to 1 on the edge that ends it.
- R4: Writes to bit 7 and to bits 6:5 have no effect. Bits 6:5 always read 0, and bit 7 always reads the monitor.
- R5: Bits 1:0 store the written value. That value drives spd_sel and reads back one edge after the write.
- R6: A write with bit 2 = 0 during a wait aborts the wait. The block stays in subclock mode and the monitor stays 0.
- R7: During a wait, a write whose bits 4:3 differ from the stored field leaves the field unchanged. wsel_err goes high for exactly one cycle, and the wait still ends at its original time.
- R8: A stop_req pulse in main clock mode enters main-stop: monitor = 0 and main_sel stays 1. A later wakeup pulse starts a wait of the stored length, and main clock mode follows when it ends.
- R9: With single_clk = 1, writes of bit 2 = 0 are ignored. Bit 2 reads 1 and the monitor stays 1.
- R10: A wakeup pulse outside main-stop has no effect, and so does a stop_req pulse outside main clock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opt_wsel | input | 2 | Reset value of the wait-select field |
| single_clk | input | 1 | Single-clock option; holds bit 2 at 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| stop_req | input | 1 | Pulse that enters main-stop from main clock mode |
| wakeup | input | 1 | Pulse that leaves main-stop through a wait |
| rd_data | output | 8 | Register read value |
| main_sel | output | 1 | 1 selects the main clock as source (main or main-stop) |
| spd_sel | output | 2 | Main clock speed select for CPU and peripherals |
| mon | output | 1 | 1 only while main clock mode is fully active |
| wsel_err | output | 1 | One-cycle flag for a refused wait-select write |

## Verification
The read-back value, spd_sel, main_sel and the monitor's fall all change on the edge that takes the write or the pulse. wsel_err is registered and is high only in the cycle after the refused write. The monitor's rise comes exactly N edges after the triggering edge, where N is the selected wait length. Inputs are driven on falling edges and outputs are sampled on falling edges. Each wait is checked at N-1 edges (must still be 0) and at N edges (must be 1), so an off-by-one in either direction is caught.

// File: rtl/clkmode_pkg.sv
// Package: shared mode encoding for the clock mode controller.
// Assumes: four modes, two-bit encoding.
package clkmode_pkg;
    typedef enum logic [1:0] {
        ST_SUB  = 2'd0,
        ST_WAIT = 2'd1,
        ST_MAIN = 2'd2,
        ST_STOP = 2'd3
    } mode_t;
endpackage

// File: rtl/clkmode_waitcnt.sv
// Stabilization wait counter. A load sets it to 2^E-1 for the selected
// exponent, and it counts down to zero. expire is high in the final
// cycle, so a wait lasts exactly 2^E edges from the load edge.
// Assumes: load is never raised while a wait is running.
module clkmode_waitcnt #(
    parameter int SEL_W = 2,
    parameter int EXP0  = 2,
    parameter int EXP1  = 12,
    parameter int EXP2  = 14,
    parameter int EXP3  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rst_sel,
    input  logic             load,
    input  logic [SEL_W-1:0] load_sel,
    input  logic             clear,
    output logic             expire
);
    localparam int MAXE  = (EXP0 > EXP1 ? EXP0 : EXP1) > (EXP2 > EXP3 ? EXP2 : EXP3)
                         ? (EXP0 > EXP1 ? EXP0 : EXP1) : (EXP2 > EXP3 ? EXP2 : EXP3);
    localparam int CNT_W = MAXE + 1;

    logic [CNT_W-1:0] cnt;
    logic             busy;

    // Map a select code to its counter preset value (2^E - 1).
    function automatic logic [CNT_W-1:0] preset(input logic [SEL_W-1:0] s);
        int e;
        case (s)
            2'd0:    e = EXP0;
            2'd1:    e = EXP1;
            2'd2:    e = EXP2;
            default: e = EXP3;
        endcase
        return CNT_W'((64'd1 << e) - 64'd1);
    endfunction

    // Load, abort or count down the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= preset(rst_sel);
            busy <= 1'b1;
        end else if (clear) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            cnt  <= preset(load_sel);
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Signal the last cycle of a running wait.
    always_comb expire = busy && (cnt == '0) && !clear && !load;

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear && !load && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
    assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expire);
endmodule

// File: rtl/clkmode_regs.sv
// Register fields: speed select, mode select and wait select.
// A write that would change the wait select during a wait is refused,
// and wsel_err flags it for one cycle. go_sub / go_main decode the
// mode-select write, taking the single-clock option into account.
// Assumes: the written fields arrive already sliced from the data word.
module clkmode_regs #(
    parameter int CS_W = 2,
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WS_W-1:0] rst_wsel,
    input  logic            single_clk,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_cs,
    input  logic            wr_scs,
    input  logic [WS_W-1:0] wr_wsel,
    input  logic            waiting,
    output logic [CS_W-1:0] cs,
    output logic            scs,
    output logic [WS_W-1:0] wsel,
    output logic            wsel_err,
    output logic            go_sub,
    output logic            go_main
);
    logic wsel_rej;

    // Decode mode requests and refused wait-select writes.
    always_comb begin
        go_sub   = wr_en && !wr_scs && !single_clk;
        go_main  = wr_en && (wr_scs || single_clk);
        wsel_rej = wr_en && waiting && (wr_wsel != wsel);
    end

    // Hold the register fields and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs       <= '0;
            scs      <= 1'b1;
            wsel     <= rst_wsel;
            wsel_err <= 1'b0;
        end else begin
            wsel_err <= wsel_rej;
            if (wr_en) begin
                cs  <= wr_cs;
                scs <= wr_scs || single_clk;
                if (!wsel_rej) wsel <= wr_wsel;
            end
        end
    end

    assert_wsel_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waiting && wr_wsel != wsel) |=> ($stable(wsel) && wsel_err));
    assert_single_scs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && single_clk) |=> scs);
endmodule

// File: rtl/clkmode_fsm.sv
// Mode sequencer: subclock, stabilization wait, main, main-stop.
// A request for subclock wins over every other event in every mode.
// Assumes: expire comes from the wait counter this sequencer loads.
module clkmode_fsm
    import clkmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_sub,
    input  logic go_main,
    input  logic stop_req,
    input  logic wakeup,
    input  logic expire,
    output logic load,
    output logic clear,
    output logic in_sub,
    output logic waiting,
    output logic mon,
    output logic main_sel
);
    mode_t state, nxt;

    // Choose the next mode and the counter commands.
    always_comb begin
        nxt   = state;
        load  = 1'b0;
        clear = 1'b0;
        if (go_sub) begin
            nxt   = ST_SUB;
            clear = 1'b1;
        end else begin
            case (state)
                ST_SUB:  if (go_main)  begin nxt = ST_WAIT; load = 1'b1; end
                ST_WAIT: if (expire)   nxt = ST_MAIN;
                ST_MAIN: if (stop_req) nxt = ST_STOP;
                ST_STOP: if (wakeup)   begin nxt = ST_WAIT; load = 1'b1; end
                default: nxt = ST_SUB;
            endcase
        end
    end

    // Register the mode; reset enters a stabilization wait.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // Decode status outputs from the mode.
    always_comb begin
        in_sub   = (state == ST_SUB);
        waiting  = (state == ST_WAIT);
        mon      = (state == ST_MAIN);
        main_sel = (state == ST_MAIN) || (state == ST_STOP);
    end

    assert_sub_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_sub |=> (!mon && !main_sel));
    assert_wait_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && expire && !go_sub) |=> mon);
    assert_mon_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mon |-> main_sel);
    assert_wake_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mon && wakeup && !stop_req && !go_sub) |=> mon);
endmodule

// File: rtl/clkmode_ctrl.sv
// Top of the clock mode controller. Places the register fields at their
// bit positions, steers the wait length (the written field when leaving
// subclock, otherwise the stored one) and connects the sequencer and
// the wait counter.
// Assumes: an 8-bit register; bits 6:5 read as zero.
module clkmode_ctrl #(
    parameter int DW   = 8,
    parameter int CS_W = 2,
    parameter int WS_W = 2,
    parameter int EXP0 = 2,
    parameter int EXP1 = 12,
    parameter int EXP2 = 14,
    parameter int EXP3 = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WS_W-1:0] opt_wsel,
    input  logic            single_clk,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            stop_req,
    input  logic            wakeup,
    output logic [DW-1:0]   rd_data,
    output logic            main_sel,
    output logic [CS_W-1:0] spd_sel,
    output logic            mon,
    output logic            wsel_err
);
    localparam int SCS_POS = CS_W;
    localparam int WS_LSB  = CS_W + 1;
    localparam int MON_POS = DW - 1;
    localparam int PAD_W   = MON_POS - (WS_LSB + WS_W);

    logic [CS_W-1:0] cs;
    logic            scs;
    logic [WS_W-1:0] wsel;
    logic [WS_W-1:0] load_sel;
    logic            go_sub, go_main, load, clear, expire, in_sub, waiting;

    clkmode_regs #(.CS_W(CS_W), .WS_W(WS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rst_wsel(opt_wsel), .single_clk(single_clk),
        .wr_en(wr_en), .wr_cs(wr_data[CS_W-1:0]), .wr_scs(wr_data[SCS_POS]),
        .wr_wsel(wr_data[WS_LSB +: WS_W]), .waiting(waiting),
        .cs(cs), .scs(scs), .wsel(wsel), .wsel_err(wsel_err),
        .go_sub(go_sub), .go_main(go_main)
    );

    clkmode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_sub(go_sub), .go_main(go_main),
        .stop_req(stop_req), .wakeup(wakeup), .expire(expire),
        .load(load), .clear(clear), .in_sub(in_sub), .waiting(waiting),
        .mon(mon), .main_sel(main_sel)
    );

    // Pick the wait length: the written field on a subclock exit.
    always_comb load_sel = in_sub ? wr_data[WS_LSB +: WS_W] : wsel;

    clkmode_waitcnt #(.SEL_W(WS_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)) u_wait (
        .clk(clk), .rst_n(rst_n), .rst_sel(opt_wsel), .load(load),
        .load_sel(load_sel), .clear(clear), .expire(expire)
    );

    // Assemble the read value and the speed select.
    always_comb begin
        rd_data = {mon, {PAD_W{1'b0}}, wsel, scs || single_clk, cs};
        spd_sel = cs;
    end

    assert_stop_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mon && stop_req && !wr_en) |=> (!mon && main_sel));
endmodule

// File: tb/clkmode_ctrl_bench.sv
`timescale 1ns/1ps
module clkmode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] opt_wsel = 2'd0;
    logic       single_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_req = 1'b0;
    logic       wakeup = 1'b0;
    logic [7:0] rd_data;
    logic       main_sel, mon, wsel_err;
    logic [1:0] spd_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkmode_ctrl u_clkmode_ctrl (
        .clk(clk), .rst_n(rst_n), .opt_wsel(opt_wsel), .single_clk(single_clk),
        .wr_en(wr_en), .wr_data(wr_data), .stop_req(stop_req), .wakeup(wakeup),
        .rd_data(rd_data), .main_sel(main_sel), .spd_sel(spd_sel), .mon(mon),
        .wsel_err(wsel_err)
    );

    // {write data, expected read value} in main mode, wait select 0
    localparam logic [15:0] VEC [8] = '{
        16'h05_85, 16'h06_86, 16'h07_87, 16'hE4_84,
        16'h64_84, 16'h0C_8C, 16'hFF_9F, 16'h04_84
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wakeup = 1'b1; @(negedge clk); wakeup = 1'b0;
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        chk("R1 reset read", int'(rd_data), 8'h04);
        edges(3);  chk("R1 mon before wait end", int'(mon), 0);
        edges(1);  chk("R1 mon at wait end", int'(mon), 1);

        for (int i = 0; i < 8; i++) begin
            do_wr(VEC[i][15:8]);
            chk("R4/R5 table read", int'(rd_data), int'(VEC[i][7:0]));
            chk("R5 spd_sel", int'(spd_sel), int'(VEC[i][1:0]));
        end

        pulse_wake();
        chk("R10 wakeup in main", int'(mon), 1);

        pulse_stop();
        chk("R8 stop mon", int'(mon), 0);
        chk("R8 stop main_sel", int'(main_sel), 1);
        edges(10); chk("R8 stays stopped", int'(mon), 0);
        pulse_wake();
        edges(3);  chk("R8 wake before end", int'(mon), 0);
        edges(1);  chk("R8 wake end", int'(mon), 1);

        do_wr(8'h00);
        chk("R2 sub mon", int'(mon), 0);
        chk("R2 sub main_sel", int'(main_sel), 0);
        chk("R2 sub read", int'(rd_data), 8'h00);

        pulse_stop();
        chk("R10 stop in sub", int'(main_sel), 0);
        pulse_wake();
        edges(10); chk("R10 wake in sub", int'(mon), 0);

        do_wr(8'h0C);
        chk("R3 waiting read", int'(rd_data), 8'h0C);
        edges(4095); chk("R3 sel1 before end", int'(mon), 0);
        edges(1);    chk("R3 sel1 end", int'(mon), 1);

        do_wr(8'h00);
        do_wr(8'h1C);
        edges(65535); chk("R3 sel3 before end", int'(mon), 0);
        edges(1);     chk("R3 sel3 end", int'(mon), 1);

        do_wr(8'h08);
        do_wr(8'h0C);
        edges(10);
        do_wr(8'h08);
        chk("R6 abort main_sel", int'(main_sel), 0);
        edges(5000); chk("R6 abort mon", int'(mon), 0);

        do_wr(8'h0C);
        do_wr(8'h14);
        chk("R7 err flag", int'(wsel_err), 1);
        chk("R7 field kept", int'(rd_data[4:3]), 1);
        edges(1);    chk("R7 err one cycle", int'(wsel_err), 0);
        edges(4093); chk("R7 before end", int'(mon), 0);
        edges(1);    chk("R7 end", int'(mon), 1);

        single_clk = 1'b1;
        do_wr(8'h00);
        chk("R9 bit2", int'(rd_data[2]), 1);
        chk("R9 mon", int'(mon), 1);
        single_clk = 1'b0;

        rst_n = 1'b0; opt_wsel = 2'd1;
        edges(2);
        rst_n = 1'b1;
        chk("R1 option field", int'(rd_data[4:3]), 1);
        edges(4095); chk("R1 opt1 before end", int'(mon), 0);
        edges(1);    chk("R1 opt1 end", int'(mon), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule